// File: doc/BRIEF.md
# RAM-Based Multi-Tap Delay Line

This block delays a stream of words and brings out several evenly spaced points of the delay. It is built as a chain of small synchronous memories, one per segment, addressed by one circular pointer, not as a long chain of flip-flops. At every enabled clock edge each segment reads the word stored at the pointer, overwrites that slot with its own input, and hands the old word on to the next segment. The last segment's old word is the delayed output. The word each segment hands on is also captured into a tap register.

The parameters are the word width `W`, the number of taps `N` and the tap spacing `M`. `M` must be at least 3, and the block refuses to elaborate for smaller values. A clock enable freezes the pointer, the memories and the outputs. An asynchronous clear and a synchronous clear each return the pointer to slot zero and zero the outputs. The memories keep their contents through a clear, so a fill counter holds each tap at zero until data written after the clear has reached it.

Top module: `tapped_delay_ram`

## Requirements
- R1: `taps` is `W*N` bits wide, with tap k in bits `[k*W +: W]`. Tap 0 is the least significant word. `dout` always equals the most significant word, tap N-1.
- R2: Let j be the number of enabled edges since the last clear. After edge j, tap k holds the `din` value sampled at enabled edge j-(k+1)*M, provided that j >= (k+1)*M+1.
- R3: An edge with `en` low and `srst` low changes nothing. `taps` and `dout` keep their values, and the delay alignment of R2 counts enabled edges only.
- R4: While `arst` is high, `taps` and `dout` are zero at once, with no clock edge needed.
- R5: A rising edge with `srst` high zeroes `taps` and `dout`, whatever the level of `en`. That edge does not count as an enabled edge.
- R6: After any clear, tap k reads zero until enabled edge (k+1)*M+1. This holds even though the memories still contain older data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| arst | input | 1 | Asynchronous clear, active high |
| srst | input | 1 | Synchronous clear, active high |
| en | input | 1 | Shift enable |
| din | input | W | Word shifted in |
| dout | output | W | Oldest word, equal to the top tap |
| taps | output | W*N | Concatenated tap words, tap 0 lowest |

## Verification
The bound checker watches, on every cycle, that an idle edge leaves the taps unchanged, that a synchronous clear zeroes them on the next edge, that an asynchronous clear holds them at zero, and that tap 0 stays zero until its fill point after any clear. The exact delay of each tap can only be shown by the bench's scenarios, because the windows it spans depend on `M`. The same holds for the alignment across gaps in the enable pattern and for recovery after clears taken in the middle of a stream. The bench keeps its own history of shifted words and derives every tap from it arithmetically.

// File: rtl/tapped_delay_ram.sv
module tapped_delay_ram #(
  parameter int W = 8,
  parameter int N = 3,
  parameter int M = 4
) (
  input  logic           clk,
  input  logic           arst,
  input  logic           srst,
  input  logic           en,
  input  logic [W-1:0]   din,
  output logic [W-1:0]   dout,
  output logic [W*N-1:0] taps
);
  localparam int PW   = (M > 1) ? $clog2(M) : 1;
  localparam int FILL = N * M;
  localparam int CW   = $clog2(FILL + 1);

  if (M < 3) begin : g_bad_spacing
    $error("tapped_delay_ram: tap spacing M must be at least 3");
  end

  logic [PW-1:0] ptr;
  logic [CW-1:0] fill;
  logic [W-1:0]  mem    [N][M];
  logic [W-1:0]  rd     [N];
  logic [W-1:0]  seg_in [N];
  logic [W-1:0]  tap_q  [N];

  wire shift = en && !srst;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      ptr  <= '0;
      fill <= '0;
    end else if (srst) begin
      ptr  <= '0;
      fill <= '0;
    end else if (en) begin
      ptr <= (ptr == PW'(M - 1)) ? '0 : ptr + 1'b1;
      if (fill != CW'(FILL)) fill <= fill + 1'b1;
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_seg
    assign rd[k] = mem[k][ptr];
    if (k == 0) begin : g_head
      assign seg_in[k] = din;
    end else begin : g_link
      assign seg_in[k] = rd[k-1];
    end

    always_ff @(posedge clk)
      if (shift) mem[k][ptr] <= seg_in[k];

    always_ff @(posedge clk or posedge arst) begin
      if (arst)       tap_q[k] <= '0;
      else if (srst)  tap_q[k] <= '0;
      else if (en)    tap_q[k] <= (fill >= CW'((k + 1) * M)) ? rd[k] : '0;
    end

    assign taps[k*W +: W] = tap_q[k];
  end

  assign dout = tap_q[N-1];
endmodule

module tapped_delay_ram_chk #(
  parameter int W = 8,
  parameter int N = 3,
  parameter int M = 4
) (
  input logic           clk,
  input logic           arst,
  input logic           srst,
  input logic           en,
  input logic [W*N-1:0] taps
);
  localparam int CW = $clog2(M + 2);
  logic [CW-1:0] seen;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)                                 seen <= '0;
    else if (srst)                            seen <= '0;
    else if (en && seen != CW'(M + 1))        seen <= seen + 1'b1;
  end

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (arst)
    (!en && !srst) |=> $stable(taps));

  assert_sync_clear_R5: assert property (@(posedge clk) disable iff (arst)
    srst |=> (taps == '0));

  assert_fill_zero_R6: assert property (@(posedge clk) disable iff (arst)
    (seen <= CW'(M)) |-> (taps[W-1:0] == '0));

  always @(negedge clk)
    if (arst) assert_async_clear_R4: assert (taps == '0);
endmodule

bind tapped_delay_ram tapped_delay_ram_chk #(.W(W), .N(N), .M(M)) u_chk (
  .clk(clk), .arst(arst), .srst(srst), .en(en), .taps(taps)
);

// File: tb/tb_tapped_delay_ram.sv
module tb_tapped_delay_ram;
  localparam int W = 8, N = 3, M = 4;

  logic clk = 0, arst = 1, srst = 0, en = 0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic [W*N-1:0] taps;

  int checks = 0, errors = 0, cnt = 0;
  logic [W-1:0] hist [0:511];
  bit done = 0;

  always #10 clk = ~clk;

  tapped_delay_ram #(.W(W), .N(N), .M(M)) dut (
    .clk(clk), .arst(arst), .srst(srst), .en(en), .din(din), .dout(dout), .taps(taps)
  );

  task automatic chk(input string req, input logic [W*N-1:0] act, input logic [W*N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [W*N-1:0] model();
    logic [W*N-1:0] v = '0;
    for (int k = 0; k < N; k++)
      if (cnt >= (k + 1) * M + 1) v[k*W +: W] = hist[cnt - (k + 1) * M];
    return v;
  endfunction

  task automatic step(input logic e, input logic s, input logic [W-1:0] d, input string req);
    en = e; srst = s; din = d;
    @(posedge clk);
    if (s) cnt = 0;
    else if (e) begin cnt++; hist[cnt] = d; end
    @(negedge clk);
    chk(req, taps, model());
    chk("R1", {{(W*N-W){1'b0}}, dout}, {{(W*N-W){1'b0}}, taps[W*N-1 -: W]});
  endtask

  initial begin
    #5000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R4 reset", taps, '0);
    arst = 0;
    @(negedge clk);
    for (int i = 0; i < 60; i++) step(1, 0, W'(i * 37 + 11), "R2 R6 continuous");
    for (int i = 0; i < 60; i++) step(i % 3 != 0, 0, W'(i * 53 + 7), "R2 R3 gapped");
    for (int i = 0; i < 5; i++)  step(0, 0, W'(i), "R3 idle");

    #3 arst = 1;
    #1 chk("R4 immediate", taps, '0);
    chk("R4 dout", {{(W*N-W){1'b0}}, dout}, '0);
    @(negedge clk);
    chk("R4 held", taps, '0);
    arst = 0; cnt = 0;
    for (int i = 0; i < 40; i++) step(1, 0, W'(i * 91 + 3), "R6 R2 after async clear");

    step(0, 1, 8'hAA, "R5 srst with en low");
    for (int i = 0; i < 20; i++) step(1, 0, W'(i * 29 + 5), "R6 after sync clear");
    step(1, 1, 8'h55, "R5 srst with en high");
    for (int i = 0; i < 45; i++) step(i % 4 != 1, 0, W'(i * 71 + 19), "R6 R2 R3 refill");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule